// File: doc/BRIEF.md
# Sequenced ADC/DAC Sample Controller

This block runs an external analog-to-digital converter and an external digital-to-analog converter on behalf of a command source and an on-chip timer. A conversion starts on a command pulse or on a periodic timer tick. The block pulls the converter's chip select low together with a convert strobe. It then waits for completion, which comes from either the converter's ready pin or an internal trigger, as configured. After that it pulses a read strobe and latches the sample. The sample is then handed to an outgoing byte stream with a valid/ready handshake.

An 8-bit multiplexer address goes out with every conversion. It is loaded from a programmable start value and steps by one after each conversion, so a row of analog channels can be scanned in turn.

On the DAC side, bytes from the command source collect in a staging register and do not touch the DAC pins. A start command copies the staged word to the DAC data lines. The block then gives one clean, single-cycle write strobe, with the data held steady on the cycle before and the cycle after it.

Top module: `adc_dac_seq`

## Requirements
- R1: While reset is held, and right after it, adc_cs_n, adc_conv_n, adc_rd_n and dac_wr_n are 1, out_valid is 0, adc_addr is 0 and dac_data_o is 0.
- R2: A one-cycle pulse on either cmd_adc_start or tmr_tick starts a conversion. adc_cs_n and adc_conv_n go low together, adc_conv_n for exactly one cycle, and adc_cs_n stays low until the read completes.
- R3: When trig_sel is 0, completion is taken from adc_rdy_i and int_trig is ignored. When trig_sel is 1, completion is taken from int_trig and adc_rdy_i is ignored. The read strobe starts in the cycle after completion.
- R4: adc_rd_n is low for exactly one cycle while adc_cs_n is low. adc_data_i is latched at the end of that cycle, and adc_cs_n returns to 1 in the next cycle.
- R5: The sample goes out as two bytes, low byte first: out_byte = sample[7:0], then {0, sample[ADC_W-1:8]} zero-extended. Each byte advances only when out_valid and out_ready are both 1. While a byte is stalled it stays unchanged and no new conversion begins.
- R6: adc_addr steps by one after every conversion and wraps from 255 to 0.
- R7: A write on start_addr_wr takes effect at the start of the next conversion. A write made during a conversion does not change that conversion's address or its increment.
- R8: Start requests that arrive while a conversion or its byte transfer is in progress are held. Any number of them cause exactly one further conversion once the block is idle.
- R9: Writes on dac_byte_wr (lane dac_byte_sel, lane 0 = bits 7:0, lane 1 = bits 15:8) change only the staging register. dac_data_o changes only on dac_start.
- R10: After dac_start, dac_data_o takes the staged word in the next cycle. dac_wr_n goes low one cycle later for exactly one cycle, and dac_data_o is unchanged on the cycles before, during and after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_adc_start | input | 1 | Command-side conversion request pulse |
| tmr_tick | input | 1 | Periodic timer conversion request pulse |
| trig_sel | input | 1 | Completion source: 0 ready pin, 1 internal trigger |
| int_trig | input | 1 | Internal completion trigger pulse |
| adc_rdy_i | input | 1 | Converter ready pin |
| start_addr_wr | input | 1 | Load strobe for the start address |
| start_addr | input | ADDR_W | Channel start address |
| adc_data_i | input | ADC_W | Converter sample bus |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_conv_n | output | 1 | Convert strobe, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_addr | output | ADDR_W | Analog multiplexer channel address |
| out_valid | output | 1 | Outgoing byte valid |
| out_byte | output | 8 | Outgoing sample byte |
| out_ready | input | 1 | Outgoing stream ready |
| dac_byte_wr | input | 1 | Staging byte write strobe |
| dac_byte_sel | input | DAC_SEL_W | Staging byte lane |
| dac_byte | input | 8 | Staging byte value |
| dac_start | input | 1 | Start DAC update command |
| dac_data_o | output | DAC_W | DAC data lines |
| dac_wr_n | output | 1 | DAC write strobe, active low |

## Verification
The bench builds the block with a 12-bit sample and a 16-bit DAC. This exercises the two-byte path, including the zero-extended upper nibble, and both staging lanes of the DAC. With the 8-bit address width, a start value of 255 reaches the wrap within a single conversion. Both completion sources are run while the unselected one is held active, so that ignoring the wrong source is actually observed.

// File: rtl/adc_dac_pkg.sv
package adc_dac_pkg;
  typedef enum logic [2:0] {
    A_IDLE, A_CONV, A_WAIT, A_READ, A_LO, A_HI
  } adc_st_t;

  typedef enum logic [1:0] {
    D_IDLE, D_SETUP, D_STROBE, D_HOLD
  } dac_st_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_dac_pkg::*;
#(
  parameter int ADC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             trig_sel,
  input  logic             int_trig,
  input  logic             adc_rdy_i,
  input  logic [ADC_W-1:0] adc_data_i,
  input  logic             out_ready,
  output logic             adc_cs_n,
  output logic             adc_conv_n,
  output logic             adc_rd_n,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             conv_start,
  output logic             conv_done
);
  localparam bit TWO_BYTES = (ADC_W > 8);

  adc_st_t          st_q, st_d;
  logic             pend_q, pend_d;
  logic [ADC_W-1:0] samp_q;
  logic             samp_en;
  logic             done;
  logic [15:0]      samp_w;

  assign done       = trig_sel ? int_trig : adc_rdy_i;
  assign conv_start = (st_q == A_IDLE) && pend_q;
  assign conv_done  = (st_q == A_READ);
  assign samp_en    = conv_done;
  assign pend_d     = (pend_q && !conv_start) || req;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      A_IDLE:  if (pend_q) st_d = A_CONV;
      A_CONV:  st_d = A_WAIT;
      A_WAIT:  if (done) st_d = A_READ;
      A_READ:  st_d = A_LO;
      A_LO:    if (out_ready) st_d = TWO_BYTES ? A_HI : A_IDLE;
      A_HI:    if (out_ready) st_d = A_IDLE;
      default: st_d = A_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= A_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       samp_q <= '0;
    else if (samp_en) samp_q <= adc_data_i;
  end

  assign samp_w     = 16'(samp_q);
  assign adc_cs_n   = !((st_q == A_CONV) || (st_q == A_WAIT) || (st_q == A_READ));
  assign adc_conv_n = (st_q != A_CONV);
  assign adc_rd_n   = (st_q != A_READ);
  assign out_valid  = (st_q == A_LO) || (st_q == A_HI);
  assign out_byte   = (st_q == A_HI) ? samp_w[15:8] : samp_w[7:0];
endmodule

// File: rtl/chan_addr_gen.sv
module chan_addr_gen #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_wr,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              conv_start,
  input  logic              conv_done,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q, addr_d, stage_q;
  logic              ld_pend_q, ld_pend_d;
  logic              addr_en;

  always_comb begin
    addr_d = addr_q;
    if (conv_start && ld_pend_q) addr_d = stage_q;
    else if (conv_done)          addr_d = addr_q + ADDR_W'(1);
  end
  assign addr_en   = conv_start || conv_done;
  assign ld_pend_d = load_wr || (ld_pend_q && !conv_start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      stage_q   <= '0;
      ld_pend_q <= 1'b0;
    end else begin
      ld_pend_q <= ld_pend_d;
      if (addr_en) addr_q  <= addr_d;
      if (load_wr) stage_q <= load_val;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/dac_stage.sv
module dac_stage
  import adc_dac_pkg::*;
#(
  parameter int DAC_W     = 16,
  parameter int DAC_SEL_W = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 byte_wr,
  input  logic [DAC_SEL_W-1:0] byte_sel,
  input  logic [7:0]           byte_val,
  input  logic                 start,
  output logic [DAC_W-1:0]     dac_data_o,
  output logic                 dac_wr_n
);
  localparam int LANES = (DAC_W + 7) / 8;

  logic [LANES*8-1:0] stage_w;
  logic [DAC_W-1:0]   out_q;
  logic               out_en;
  dac_st_t            st_q, st_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_q;
    logic       lane_en;
    assign lane_en = byte_wr && (byte_sel == DAC_SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (lane_en) lane_q <= byte_val;
    end
    assign stage_w[g*8 +: 8] = lane_q;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      D_IDLE:   if (start) st_d = D_SETUP;
      D_SETUP:  st_d = D_STROBE;
      D_STROBE: st_d = D_HOLD;
      D_HOLD:   st_d = D_IDLE;
      default:  st_d = D_IDLE;
    endcase
  end
  assign out_en = (st_q == D_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= D_IDLE;
      out_q <= '0;
    end else begin
      st_q <= st_d;
      if (out_en) out_q <= stage_w[DAC_W-1:0];
    end
  end

  assign dac_data_o = out_q;
  assign dac_wr_n   = (st_q != D_STROBE);
endmodule

// File: rtl/adc_dac_seq.sv
module adc_dac_seq #(
  parameter int ADC_W     = 12,
  parameter int DAC_W     = 16,
  parameter int ADDR_W    = 8,
  parameter int DAC_SEL_W = (DAC_W > 8) ? $clog2((DAC_W + 7) / 8) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_adc_start,
  input  logic                 tmr_tick,
  input  logic                 trig_sel,
  input  logic                 int_trig,
  input  logic                 adc_rdy_i,
  input  logic                 start_addr_wr,
  input  logic [ADDR_W-1:0]    start_addr,
  input  logic [ADC_W-1:0]     adc_data_i,
  output logic                 adc_cs_n,
  output logic                 adc_conv_n,
  output logic                 adc_rd_n,
  output logic [ADDR_W-1:0]    adc_addr,
  output logic                 out_valid,
  output logic [7:0]           out_byte,
  input  logic                 out_ready,
  input  logic                 dac_byte_wr,
  input  logic [DAC_SEL_W-1:0] dac_byte_sel,
  input  logic [7:0]           dac_byte,
  input  logic                 dac_start,
  output logic [DAC_W-1:0]     dac_data_o,
  output logic                 dac_wr_n
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  logic       conv_start, conv_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  adc_seq_ctrl #(.ADC_W(ADC_W)) i_adc (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .req        (cmd_adc_start | tmr_tick),
    .trig_sel   (trig_sel),
    .int_trig   (int_trig),
    .adc_rdy_i  (adc_rdy_i),
    .adc_data_i (adc_data_i),
    .out_ready  (out_ready),
    .adc_cs_n   (adc_cs_n),
    .adc_conv_n (adc_conv_n),
    .adc_rd_n   (adc_rd_n),
    .out_valid  (out_valid),
    .out_byte   (out_byte),
    .conv_start (conv_start),
    .conv_done  (conv_done)
  );

  chan_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .load_wr    (start_addr_wr),
    .load_val   (start_addr),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .addr       (adc_addr)
  );

  dac_stage #(.DAC_W(DAC_W), .DAC_SEL_W(DAC_SEL_W)) i_dac (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .byte_wr    (dac_byte_wr),
    .byte_sel   (dac_byte_sel),
    .byte_val   (dac_byte),
    .start      (dac_start),
    .dac_data_o (dac_data_o),
    .dac_wr_n   (dac_wr_n)
  );
endmodule

// File: rtl/adc_dac_seq_chk.sv
module adc_dac_seq_chk #(
  parameter int DAC_W  = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adc_cs_n,
  input logic              adc_conv_n,
  input logic              adc_rd_n,
  input logic [ADDR_W-1:0] adc_addr,
  input logic              out_valid,
  input logic [7:0]        out_byte,
  input logic              out_ready,
  input logic [DAC_W-1:0]  dac_data_o,
  input logic              dac_wr_n
);
  // R2
  strobe_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_conv_n || !adc_rd_n) |-> !adc_cs_n);
  // R2
  conv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_conv_n |=> adc_conv_n);
  // R4
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rd_n |=> (adc_cs_n && adc_rd_n));
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));
  // R5
  no_conv_in_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> adc_cs_n);
  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rd_n |=> (adc_addr == $past(adc_addr) + ADDR_W'(1)));
  // R10
  dac_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n |=> dac_wr_n);
  // R10
  dac_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_wr_n) |-> $stable(dac_data_o));
  // R10
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n |=> $stable(dac_data_o));
endmodule

bind adc_dac_seq adc_dac_seq_chk #(.DAC_W(DAC_W), .ADDR_W(ADDR_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .adc_cs_n   (adc_cs_n),
  .adc_conv_n (adc_conv_n),
  .adc_rd_n   (adc_rd_n),
  .adc_addr   (adc_addr),
  .out_valid  (out_valid),
  .out_byte   (out_byte),
  .out_ready  (out_ready),
  .dac_data_o (dac_data_o),
  .dac_wr_n   (dac_wr_n)
);

// File: tb/test_adc_dac_seq.sv
module test_adc_dac_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADC_W = 12;
  localparam int DAC_W = 16;
  localparam int NVEC  = 5;
  // {trig_sel, start address, sample}
  localparam logic [20:0] VECS [NVEC] = '{
    {1'b0, 8'h10, 12'hABC},
    {1'b1, 8'h22, 12'h5A3},
    {1'b0, 8'hFF, 12'h0F0},
    {1'b1, 8'h00, 12'hFFF},
    {1'b0, 8'h7E, 12'h001}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_adc_start, tmr_tick, trig_sel, int_trig, adc_rdy_i;
  logic start_addr_wr;
  logic [7:0] start_addr;
  logic [ADC_W-1:0] adc_data_i;
  logic adc_cs_n, adc_conv_n, adc_rd_n;
  logic [7:0] adc_addr;
  logic out_valid, out_ready;
  logic [7:0] out_byte;
  logic dac_byte_wr, dac_byte_sel, dac_start, dac_wr_n;
  logic [7:0] dac_byte;
  logic [DAC_W-1:0] dac_data_o;

  int n_vec = 0;
  int n_err = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_dac_seq #(.ADC_W(ADC_W), .DAC_W(DAC_W)) i_adc_dac_seq (
    .clk(clk), .rst_n(rst_n), .cmd_adc_start(cmd_adc_start), .tmr_tick(tmr_tick),
    .trig_sel(trig_sel), .int_trig(int_trig), .adc_rdy_i(adc_rdy_i),
    .start_addr_wr(start_addr_wr), .start_addr(start_addr), .adc_data_i(adc_data_i),
    .adc_cs_n(adc_cs_n), .adc_conv_n(adc_conv_n), .adc_rd_n(adc_rd_n),
    .adc_addr(adc_addr), .out_valid(out_valid), .out_byte(out_byte),
    .out_ready(out_ready), .dac_byte_wr(dac_byte_wr), .dac_byte_sel(dac_byte_sel),
    .dac_byte(dac_byte), .dac_start(dac_start), .dac_data_o(dac_data_o),
    .dac_wr_n(dac_wr_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_req(input bit use_tmr);
    @(negedge clk);
    if (use_tmr) tmr_tick = 1'b1; else cmd_adc_start = 1'b1;
    @(negedge clk);
    tmr_tick = 1'b0; cmd_adc_start = 1'b0;
  endtask

  task automatic write_start(input logic [7:0] a);
    @(negedge clk);
    start_addr = a; start_addr_wr = 1'b1;
    @(negedge clk);
    start_addr_wr = 1'b0;
  endtask

  // waits until the convert strobe is seen, checks the address there
  task automatic wait_conv(input logic [7:0] exp_addr, input string tag);
    bit seen = 0;
    for (int i = 0; i < 30 && !seen; i++) begin
      @(negedge clk);
      if (!adc_conv_n) seen = 1;
    end
    chk(seen, {"R2 convert strobe ", tag}, seen, 1);
    chk(!adc_cs_n, {"R2 cs with convert ", tag}, adc_cs_n, 0);
    chk(adc_addr == exp_addr, {"R7 address at conversion ", tag}, adc_addr, exp_addr);
  endtask

  // drives the wrong completion source, then the right one
  task automatic complete(input bit mode, input string tag);
    trig_sel = mode;
    @(negedge clk);
    chk(adc_conv_n && !adc_cs_n, {"R2 convert one cycle, cs held ", tag},
        {adc_conv_n, adc_cs_n}, 2'b10);
    if (mode) adc_rdy_i = 1'b1; else int_trig = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(adc_rd_n, {"R3 wrong source ignored ", tag}, adc_rd_n, 1);
    end
    adc_rdy_i = 1'b0; int_trig = 1'b0;
    if (mode) int_trig = 1'b1; else adc_rdy_i = 1'b1;
    @(negedge clk);
    adc_rdy_i = 1'b0; int_trig = 1'b0;
    chk(!adc_rd_n && !adc_cs_n, {"R4 read strobe ", tag}, {adc_rd_n, adc_cs_n}, 0);
  endtask

  task automatic expect_bytes(input logic [ADC_W-1:0] s, input string tag);
    logic [15:0] w = 16'(s);
    @(negedge clk);
    chk(adc_cs_n && adc_rd_n, {"R4 cs released ", tag}, {adc_cs_n, adc_rd_n}, 2'b11);
    chk(out_valid && out_byte == w[7:0], {"R5 low byte ", tag}, out_byte, w[7:0]);
    @(negedge clk);
    chk(out_valid && out_byte == w[15:8], {"R5 high byte ", tag}, out_byte, w[15:8]);
    @(negedge clk);
    chk(!out_valid, {"R5 stream idle ", tag}, out_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_adc_start = 0; tmr_tick = 0; trig_sel = 0; int_trig = 0;
    adc_rdy_i = 0; start_addr_wr = 0; start_addr = '0; adc_data_i = '0;
    out_ready = 1'b1; dac_byte_wr = 0; dac_byte_sel = 0; dac_byte = '0; dac_start = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(adc_cs_n && adc_conv_n && adc_rd_n && dac_wr_n && !out_valid,
        "R1 strobes in reset", {adc_cs_n, adc_conv_n, adc_rd_n, dac_wr_n, out_valid}, 5'b11110);
    chk(adc_addr == 0 && dac_data_o == 0, "R1 address and dac in reset", adc_addr, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(adc_cs_n && adc_conv_n && adc_rd_n && dac_wr_n && !out_valid,
        "R1 strobes after reset", {adc_cs_n, adc_conv_n, adc_rd_n, dac_wr_n, out_valid}, 5'b11110);

    // vector table: R2 R3 R4 R5 R6 over both sources and completion modes
    for (int v = 0; v < NVEC; v++) begin
      logic [20:0] e = VECS[v];
      adc_data_i = e[11:0];
      write_start(e[19:12]);
      pulse_req(v[0]);
      wait_conv(e[19:12], $sformatf("vec%0d", v));
      complete(e[20], $sformatf("vec%0d", v));
      expect_bytes(e[11:0], $sformatf("vec%0d", v));
      chk(adc_addr == e[19:12] + 8'd1, $sformatf("R6 step/wrap vec%0d", v),
          adc_addr, e[19:12] + 8'd1);
    end

    // R7: a write during a conversion waits for the next one
    adc_data_i = 12'h321;
    write_start(8'h40);
    pulse_req(1'b0);
    wait_conv(8'h40, "r7_a");
    write_start(8'h80);
    complete(1'b0, "r7_a");
    expect_bytes(12'h321, "r7_a");
    chk(adc_addr == 8'h41, "R7 late write not applied", adc_addr, 8'h41);
    pulse_req(1'b1);
    wait_conv(8'h80, "r7_b");
    complete(1'b1, "r7_b");
    expect_bytes(12'h321, "r7_b");

    // R8: several requests in flight collapse into one further conversion
    adc_data_i = 12'h9C5;
    pulse_req(1'b0);
    wait_conv(8'h81, "r8_a");
    pulse_req(1'b0);
    pulse_req(1'b1);
    @(negedge clk);
    complete(1'b0, "r8_a");
    expect_bytes(12'h9C5, "r8_a");
    wait_conv(8'h82, "r8_b");
    complete(1'b0, "r8_b");
    expect_bytes(12'h9C5, "r8_b");
    begin
      int lows = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (!adc_cs_n) lows++;
      end
      chk(lows == 0, "R8 exactly one extra conversion", lows, 0);
    end

    // R5 stall: byte held, no conversion while stalled
    adc_data_i = 12'h7E4;
    out_ready = 1'b0;
    pulse_req(1'b0);
    wait_conv(8'h83, "r5_stall");
    complete(1'b0, "r5_stall");
    @(negedge clk);
    chk(out_valid && out_byte == 8'hE4, "R5 stalled low byte", out_byte, 8'hE4);
    cmd_adc_start = 1'b1;
    @(negedge clk);
    cmd_adc_start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(out_valid && out_byte == 8'hE4 && adc_cs_n, "R5 stall holds, no conversion",
          {out_valid, adc_cs_n, out_byte}, {2'b11, 8'hE4});
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid && out_byte == 8'h07, "R5 high byte after stall", out_byte, 8'h07);
    wait_conv(8'h84, "r5_pending");
    complete(1'b1, "r5_pending");
    expect_bytes(12'h7E4, "r5_pending");

    // R9: staging does not reach the pins
    @(negedge clk);
    dac_byte_wr = 1'b1; dac_byte_sel = 1'b0; dac_byte = 8'h34;
    @(negedge clk);
    dac_byte_sel = 1'b1; dac_byte = 8'h12;
    @(negedge clk);
    dac_byte_wr = 1'b0;
    @(negedge clk);
    chk(dac_data_o == 0 && dac_wr_n, "R9 staged bytes not applied", dac_data_o, 0);
    // R10: update sequence
    dac_start = 1'b1;
    @(negedge clk);
    dac_start = 1'b0;
    chk(dac_data_o == 16'h1234 && dac_wr_n, "R10 data before strobe",
        dac_data_o, 16'h1234);
    dac_byte_wr = 1'b1; dac_byte_sel = 1'b0; dac_byte = 8'hAB;
    @(negedge clk);
    dac_byte_wr = 1'b0;
    chk(!dac_wr_n && dac_data_o == 16'h1234, "R10 strobe low, data stable",
        {dac_wr_n, dac_data_o}, {1'b0, 16'h1234});
    @(negedge clk);
    chk(dac_wr_n && dac_data_o == 16'h1234, "R10 strobe one cycle, data held",
        {dac_wr_n, dac_data_o}, {1'b1, 16'h1234});
    repeat (2) @(negedge clk);
    chk(dac_data_o == 16'h1234, "R9 restaged byte not applied", dac_data_o, 16'h1234);
    dac_start = 1'b1;
    @(negedge clk);
    dac_start = 1'b0;
    chk(dac_data_o == 16'h12AB, "R10 second update", dac_data_o, 16'h12AB);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule